// File: doc/BRIEF.md
# Fast Multi-Unit Page Program Sequencer

This block sits at the front of the command interface of a parallel NOR flash device. It watches bus write cycles and recognises the fast page program commands. In byte mode these write two, four or eight adjacent bytes as one page. In word mode they write two or four adjacent words. A setup cycle names the page size. The block then latches one address/data pair per write cycle and checks that every address after the first falls inside the same aligned page. After the last pair it raises a one-cycle start request toward the program/erase controller. The assembled page goes with that request: its base address, unit count, width and data.

Fast programming is allowed only while the high-voltage enable input is asserted. While that input is high, the block also tells the protection logic to treat every block as unprotected. A setup cycle without high voltage does nothing. If the voltage drops before the sequence completes, or an address strays out of the page, the sequence is dropped and the block returns to read mode without starting the controller. Once programming has started, the block reports busy until the controller signals completion. During that time it accepts only a suspend command, and after a suspend only a resume command.

Top module: `fast_prog_seq`

## Requirements
- R1: After reset, busy, startPulse, suspendReq and resumeReq are all low.
- R2: A setup write is recognised by its low data byte: 0x50 selects two units, 0x56 four units, 0x8B eight units. It is accepted only when hvEn is high in that cycle. Otherwise the write is ignored and later pair writes start nothing.
- R3: Each accepted pair is stored by the low page-offset bits of its address. In byte mode wrData[7:0] goes to pageData[8k+7:8k]. In word mode wrData goes to pageData[16k+15:16k]. Lanes that no pair wrote read all ones.
- R4: In the cycle after the final pair (2, 4 or 8), startPulse is high for exactly one cycle. In that cycle pageAddr equals the first pair's address with its low log2(n) bits cleared, pageUnits equals n, and pageWide equals the wideMode value sampled at setup.
- R5: A pair whose address differs from the first pair's address outside the low log2(n) bits aborts the sequence with no start, and the block returns to read mode.
- R6: If hvEn is low in any cycle between setup and the final pair, the sequence aborts with no start.
- R7: busy rises together with startPulse and falls in the cycle after a peDone pulse that arrives while running. A peDone pulse while not busy has no effect.
- R8: While running, a write with low byte 0xB0 raises suspendReq for one cycle and busy stays high. Any other write while busy starts nothing and leaves pageData unchanged.
- R9: While suspended, a write with low byte 0x30 raises resumeReq for one cycle. Other writes and peDone are ignored while suspended, and busy stays high.
- R10: unprotectAll follows hvEn.
- R11: In word mode (wideMode high) the eight-unit code 0x8B is not a command, and the pair writes that follow it start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | One-cycle bus write strobe |
| wrAddr | input | ADDR_W | Write address (byte address in byte mode, word address in word mode) |
| wrData | input | DATA_W | Write data |
| wideMode | input | 1 | High selects word organisation |
| hvEn | input | 1 | High-voltage level present on the program enable pin |
| peDone | input | 1 | Completion pulse from the program/erase controller |
| unprotectAll | output | 1 | Protection override while high voltage is present |
| startPulse | output | 1 | One-cycle start request to the controller |
| busy | output | 1 | Programming running or suspended |
| suspendReq | output | 1 | One-cycle suspend request |
| resumeReq | output | 1 | One-cycle resume request |
| pageAddr | output | ADDR_W | Aligned page base address |
| pageData | output | 8*DATA_W/2 | Assembled page data |
| pageUnits | output | 4 | Number of units in the page |
| pageWide | output | 1 | Page is made of words |

## Verification
The properties assume that peDone is a single-cycle pulse and that wrAddr and wrData are steady for the whole cycle in which wrEn is high. They also assume hvEn changes only between clock edges. The bench drives every input at the falling edge and holds each write for exactly one cycle, so every strobe it creates is sampled once. It sends peDone only as a one-cycle pulse, including the stray pulses that arrive while idle or suspended.

// File: rtl/fpseq_pkg.sv
package fpseq_pkg;
  localparam int PAGE_BYTES = 8;
  localparam int LANE_W     = $clog2(PAGE_BYTES);
  localparam int UNIT_W     = LANE_W + 1;
  localparam int LOW_W      = $clog2(LANE_W + 1);

  localparam logic [7:0] CMD_DOUBLE  = 8'h50;
  localparam logic [7:0] CMD_QUAD    = 8'h56;
  localparam logic [7:0] CMD_OCT     = 8'h8B;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_RESUME  = 8'h30;

  typedef enum logic [1:0] {S_READ, S_LOAD, S_RUN, S_SUSP} seqState_t;

  typedef struct packed {
    logic             setup;
    logic             pair;
    logic             first;
    logic             wide;
    logic [LOW_W-1:0] lowBits;
  } fpStrobe_t;
endpackage

// File: rtl/fpseq_ctrl.sv
module fpseq_ctrl
  import fpseq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic [7:0] cmdByte,
  input  logic      wideMode,
  input  logic      hvEn,
  input  logic      peDone,
  input  logic      inPage,
  output fpStrobe_t strb,
  output logic      startPulse,
  output logic      suspendReq,
  output logic      resumeReq,
  output logic      busy
);
  seqState_t         state;
  logic [UNIT_W-1:0] remain;
  logic              firstR;
  logic              isCmd;
  logic [LOW_W-1:0]  cmdLow;
  logic [UNIT_W-1:0] cmdUnits;

  always_comb begin
    isCmd  = 1'b0;
    cmdLow = '0;
    case (cmdByte)
      CMD_DOUBLE: begin isCmd = 1'b1;      cmdLow = LOW_W'(1); end
      CMD_QUAD:   begin isCmd = 1'b1;      cmdLow = LOW_W'(2); end
      CMD_OCT:    begin isCmd = !wideMode; cmdLow = LOW_W'(3); end
      default:    begin isCmd = 1'b0;      cmdLow = '0;        end
    endcase
  end

  assign cmdUnits = UNIT_W'(1) << cmdLow;

  always_comb begin
    strb         = '0;
    strb.setup   = (state == S_READ) && wrEn && isCmd && hvEn;
    strb.lowBits = cmdLow;
    strb.wide    = wideMode;
    strb.pair    = (state == S_LOAD) && hvEn && wrEn && (firstR || inPage);
    strb.first   = firstR;
  end

  assign busy = (state == S_RUN) || (state == S_SUSP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_READ;
      remain     <= '0;
      firstR     <= 1'b0;
      startPulse <= 1'b0;
      suspendReq <= 1'b0;
      resumeReq  <= 1'b0;
    end else begin
      startPulse <= 1'b0;
      suspendReq <= 1'b0;
      resumeReq  <= 1'b0;
      unique case (state)
        S_READ: if (strb.setup) begin
          state  <= S_LOAD;
          remain <= cmdUnits;
          firstR <= 1'b1;
        end
        S_LOAD: begin
          if (strb.pair) begin
            firstR <= 1'b0;
            remain <= remain - UNIT_W'(1);
            if (remain == UNIT_W'(1)) begin
              state      <= S_RUN;
              startPulse <= 1'b1;
            end
          end else if (!hvEn || wrEn) begin
            state <= S_READ;
          end
        end
        S_RUN: begin
          if (peDone) state <= S_READ;
          else if (wrEn && cmdByte == CMD_SUSPEND) begin
            state      <= S_SUSP;
            suspendReq <= 1'b1;
          end
        end
        S_SUSP: if (wrEn && cmdByte == CMD_RESUME) begin
          state     <= S_RUN;
          resumeReq <= 1'b1;
        end
        default: state <= S_READ;
      endcase
    end
  end
endmodule

// File: rtl/fpseq_data.sv
module fpseq_data
  import fpseq_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  fpStrobe_t                         strb,
  input  logic [ADDR_W-1:0]                 wrAddr,
  input  logic [DATA_W-1:0]                 wrData,
  output logic                              inPage,
  output logic [ADDR_W-1:0]                 pageAddr,
  output logic [PAGE_BYTES*(DATA_W/2)-1:0]  pageData,
  output logic [UNIT_W-1:0]                 pageUnits,
  output logic                              pageWide
);
  localparam int BYTE_W = DATA_W / 2;
  localparam int WORDS  = PAGE_BYTES / 2;

  logic [LOW_W-1:0]  lowR;
  logic [ADDR_W-1:0] baseR;
  logic [ADDR_W-1:0] mask;
  logic [LANE_W-1:0] laneIdx;

  assign mask      = ~({ADDR_W{1'b1}} << lowR);
  assign inPage    = ((wrAddr ^ baseR) & ~mask) == '0;
  assign laneIdx   = wrAddr[LANE_W-1:0] & mask[LANE_W-1:0];
  assign pageAddr  = baseR;
  assign pageUnits = UNIT_W'(1) << lowR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowR     <= '0;
      baseR    <= '0;
      pageWide <= 1'b0;
      pageData <= '1;
    end else if (strb.setup) begin
      lowR     <= strb.lowBits;
      pageWide <= strb.wide;
      pageData <= '1;
    end else if (strb.pair) begin
      if (strb.first) baseR <= wrAddr & ~mask;
      for (int k = 0; k < PAGE_BYTES; k++)
        if (!pageWide && laneIdx == LANE_W'(k))
          pageData[k*BYTE_W +: BYTE_W] <= wrData[BYTE_W-1:0];
      for (int k = 0; k < WORDS; k++)
        if (pageWide && laneIdx == LANE_W'(k))
          pageData[k*DATA_W +: DATA_W] <= wrData;
    end
  end
endmodule

// File: rtl/fast_prog_seq.sv
module fast_prog_seq
  import fpseq_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic [ADDR_W-1:0]                wrAddr,
  input  logic [DATA_W-1:0]                wrData,
  input  logic                             wideMode,
  input  logic                             hvEn,
  input  logic                             peDone,
  output logic                             unprotectAll,
  output logic                             startPulse,
  output logic                             busy,
  output logic                             suspendReq,
  output logic                             resumeReq,
  output logic [ADDR_W-1:0]                pageAddr,
  output logic [PAGE_BYTES*(DATA_W/2)-1:0] pageData,
  output logic [UNIT_W-1:0]                pageUnits,
  output logic                             pageWide
);
  fpStrobe_t strb;
  logic      inPage;

  assign unprotectAll = hvEn;

  fpseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .cmdByte(wrData[7:0]),
    .wideMode(wideMode), .hvEn(hvEn), .peDone(peDone), .inPage(inPage),
    .strb(strb), .startPulse(startPulse), .suspendReq(suspendReq),
    .resumeReq(resumeReq), .busy(busy)
  );

  fpseq_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .wrData(wrData),
    .inPage(inPage), .pageAddr(pageAddr), .pageData(pageData),
    .pageUnits(pageUnits), .pageWide(pageWide)
  );
endmodule

// File: rtl/fast_prog_seq_chk.sv
module fast_prog_seq_chk
  import fpseq_pkg::*;
#(
  parameter int PAGE_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              hvEn,
  input logic              peDone,
  input logic              startPulse,
  input logic              busy,
  input logic              suspendReq,
  input logic              resumeReq,
  input logic [PAGE_W-1:0] pageData,
  input logic [UNIT_W-1:0] pageUnits,
  input logic              pageWide
);
  assert_start_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);
  assert_units_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $countones(pageUnits) == 1);
  assert_start_hv_R6: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(hvEn));
  assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> busy);
  assert_busy_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> startPulse);
  assert_busy_fall_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(peDone));
  assert_page_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !startPulse) |-> $stable(pageData));
  assert_suspend_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    suspendReq |-> busy);
  assert_resume_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    resumeReq |-> busy);
  assert_word_units_R11: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && pageWide) |-> pageUnits <= UNIT_W'(4));
endmodule

bind fast_prog_seq fast_prog_seq_chk #(.PAGE_W(PAGE_BYTES*(DATA_W/2))) u_chk (
  .clk(clk), .rstN(rstN), .hvEn(hvEn), .peDone(peDone),
  .startPulse(startPulse), .busy(busy), .suspendReq(suspendReq),
  .resumeReq(resumeReq), .pageData(pageData), .pageUnits(pageUnits),
  .pageWide(pageWide)
);

// File: tb/fast_prog_seq_bench.sv
`timescale 1ns/1ps
module fast_prog_seq_bench;
  localparam int AW = 22;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic wideMode = 1'b0;
  logic hvEn = 1'b0;
  logic peDone = 1'b0;
  logic unprotectAll, startPulse, busy, suspendReq, resumeReq, pageWide;
  logic [AW-1:0] pageAddr;
  logic [63:0] pageData;
  logic [3:0] pageUnits;

  int nRun = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  fast_prog_seq u_fast_prog_seq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wideMode(wideMode), .hvEn(hvEn), .peDone(peDone),
    .unprotectAll(unprotectAll), .startPulse(startPulse), .busy(busy),
    .suspendReq(suspendReq), .resumeReq(resumeReq), .pageAddr(pageAddr),
    .pageData(pageData), .pageUnits(pageUnits), .pageWide(pageWide)
  );

  typedef struct packed {
    logic          wide;
    logic [7:0]    cmd;
    logic [AW-1:0] addr;
    logic          rev;
    logic [3:0]    badIdx;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 8'h50, 22'h000101, 1'b0, 4'hF},
    '{1'b0, 8'h56, 22'h001236, 1'b0, 4'hF},
    '{1'b0, 8'h8B, 22'h003F08, 1'b1, 4'hF},
    '{1'b1, 8'h50, 22'h000AA2, 1'b0, 4'hF},
    '{1'b1, 8'h56, 22'h012344, 1'b1, 4'hF},
    '{1'b0, 8'h56, 22'h000200, 1'b0, 4'd2},
    '{1'b1, 8'h50, 22'h000010, 1'b0, 4'd1},
    '{1'b0, 8'h8B, 22'h3FFFF8, 1'b0, 4'd7}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic donePulse();
    @(negedge clk);
    peDone = 1'b1;
    @(negedge clk);
    peDone = 1'b0;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    logic [63:0] expData;
    logic [63:0] heldData;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 start", 64'(startPulse), 64'd0);
    check("R1 suspend/resume", {62'd0, suspendReq, resumeReq}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R10 protection override follows hvEn
    check("R10 low", 64'(unprotectAll), 64'd0);
    hvEn = 1'b1;
    #1 check("R10 high", 64'(unprotectAll), 64'd1);

    // table walk: R3 R4 R5
    for (int v = 0; v < 8; v++) begin
      int n;
      logic [AW-1:0] base;
      bit aborted;
      n = (VECS[v].cmd == 8'h50) ? 2 : (VECS[v].cmd == 8'h56) ? 4 : 8;
      base = VECS[v].addr & ~AW'(n - 1);
      wideMode = VECS[v].wide;
      expData = '1;
      aborted = 1'b0;
      busWrite(22'h0, {8'h00, VECS[v].cmd});
      for (int i = 0; i < n; i++) begin
        int off;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        off = VECS[v].rev ? (n - 1 - i) : i;
        a = base + AW'(off);
        d = VECS[v].wide ? (16'hA500 + 16'(i * 17)) : {8'hEE, 8'(8'h40 + i)};
        if (i == int'(VECS[v].badIdx)) begin
          busWrite(a ^ 22'h000100, d);
          check("R5 no start on stray address", 64'(startPulse), 64'd0);
          check("R5 not busy after abort", 64'(busy), 64'd0);
          aborted = 1'b1;
          break;
        end
        if (VECS[v].wide) expData[off*16 +: 16] = d;
        else expData[off*8 +: 8] = d[7:0];
        busWrite(a, d);
        if (i < n - 1) check("R4 no early start", 64'(startPulse), 64'd0);
      end
      if (!aborted) begin
        check("R4 start pulse", 64'(startPulse), 64'd1);
        check("R4 page address", 64'(pageAddr), 64'(base));
        check("R4 page units", 64'(pageUnits), 64'(n));
        check("R4 page width", 64'(pageWide), 64'(VECS[v].wide));
        check("R3 page data", pageData, expData);
        check("R7 busy on start", 64'(busy), 64'd1);
        @(negedge clk);
        check("R4 single pulse", 64'(startPulse), 64'd0);
        donePulse();
        check("R7 idle after done", 64'(busy), 64'd0);
      end
    end

    // R2 setup without high voltage ignored
    wideMode = 1'b0;
    hvEn = 1'b0;
    busWrite(22'h40, 16'h0050);
    hvEn = 1'b1;
    busWrite(22'h40, 16'h0041);
    busWrite(22'h41, 16'h0042);
    check("R2 no start without hv", {62'd0, startPulse, busy}, 64'd0);

    // R11 octuple code not a command in word mode
    wideMode = 1'b1;
    busWrite(22'h80, 16'h008B);
    for (int i = 0; i < 8; i++) busWrite(22'h80 + AW'(i), 16'h0001);
    check("R11 no start", {62'd0, startPulse, busy}, 64'd0);
    wideMode = 1'b0;

    // R6 enable drop mid-sequence
    busWrite(22'h100, 16'h0056);
    busWrite(22'h100, 16'h0041);
    @(negedge clk); hvEn = 1'b0;
    @(negedge clk); hvEn = 1'b1;
    for (int i = 1; i < 4; i++) begin
      busWrite(22'h100 + AW'(i), 16'h0041);
      check("R6 no start after hv drop", {62'd0, startPulse, busy}, 64'd0);
    end

    // R7 R8 R9 busy, suspend, resume
    busWrite(22'h200, 16'h0012);
    donePulse();
    check("R7 done while idle", 64'(busy), 64'd0);
    busWrite(22'h0, 16'h0050);
    busWrite(22'h200, 16'h0012);
    busWrite(22'h201, 16'h0034);
    check("R4 start directed", 64'(startPulse), 64'd1);
    heldData = pageData;
    busWrite(22'h0, 16'h0050);
    busWrite(22'h300, 16'h0077);
    busWrite(22'h301, 16'h0077);
    check("R8 no start while busy", 64'(startPulse), 64'd0);
    check("R8 page held", pageData, heldData);
    busWrite(22'h0, 16'h00B0);
    check("R8 suspend req", 64'(suspendReq), 64'd1);
    check("R8 busy in suspend", 64'(busy), 64'd1);
    @(negedge clk);
    check("R8 suspend single", 64'(suspendReq), 64'd0);
    donePulse();
    check("R9 done ignored in suspend", 64'(busy), 64'd1);
    busWrite(22'h0, 16'h00B0);
    check("R9 other write ignored", {62'd0, suspendReq, resumeReq}, 64'd0);
    busWrite(22'h0, 16'h0030);
    check("R9 resume req", 64'(resumeReq), 64'd1);
    check("R9 busy after resume", 64'(busy), 64'd1);
    donePulse();
    check("R7 done after resume", 64'(busy), 64'd0);

    finishRun();
  end
endmodule